// File: doc/BRIEF.md
# DSP Control Register and Accumulator Maintenance Unit

This block holds the 32-bit control and status word of a DSP datapath, together with a file of four 64-bit accumulators, each split into a HI and a LO half. Software-visible access to the control word is field-granular. A 6-bit field mask picks which fields a write replaces and which fields a read returns. Execution units can also set overflow bits and the extract-fail flag through sideband inputs, and they can load the bit-position field directly.

Two accumulator maintenance operations run on the file. The shift operation moves a whole HI:LO pair by a signed amount. The push operation moves LO up into HI, loads new data into LO, and advances the stored bit position so that bit-field walking can go on across pushes. Commands enter on two valid/ready channels, one for control writes and one for accumulator operations. Each channel takes a command when valid and ready are both high. Ready is held high at all times, so the block never applies back-pressure, and a command issued while valid is high is never held over to a later cycle. The control read port and the accumulator read port are combinational.

Top module: `dspc_unit`

## Requirements
- R1: On synchronous reset (rst_n low at a clock edge), the control word and every accumulator half become zero.
- R2: An accepted write replaces only the fields its mask selects, and every other bit keeps its value. The mask bits map to fields as follows: bit 0 selects the position field [5:0], bit 1 the shift-count field [12:7], bit 2 the carry bit [13], bit 5 the extract-fail bit [14], bit 3 the overflow field [23:16], and bit 4 the condition field [31:24].
- R3: The read port returns the fields chosen by rd_mask in their own bit positions, using the same mask-to-field map as R2. Every bit outside the chosen fields reads as zero.
- R4: Bits 6 and 15 of the control word always read zero, and writes to them have no effect.
- R5: A high bit on set_ovf sets the matching bit of [23:16], and set_efail sets bit 14. When a write in the same cycle targets the same bit, the set wins.
- R6: pos_load loads pos_value into field [5:0]. It takes priority over both a push increment and a masked write in the same cycle.
- R7: A push (acc_op=1) on accumulator acc_sel copies the old LO into HI and acc_operand into LO.
- R8: On a push, if the position field is 32 or less, 32 is added to it, wrapping modulo 64 (so 32 becomes 0). If the field is above 32 it is left unchanged. A push increment takes priority over a masked write of the position field.
- R9: A shift (acc_op=0) with a positive amount, given as acc_operand[5:0] in two's complement, shifts the 64-bit HI:LO logically right by that amount.
- R10: A shift with a negative amount shifts HI:LO left by its magnitude (an amount of -32 moves LO into HI and clears LO). An amount of zero leaves the pair unchanged.
- R11: An accumulator operation changes only the entry chosen by acc_sel.
- R12: wr_ready and acc_ready are always high. An accepted command takes effect at the clock edge that accepts it and is visible on the read ports right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Control write command valid |
| wr_ready | output | 1 | Control write ready (always high) |
| wr_data | input | 32 | Control write data |
| wr_mask | input | 6 | Field mask for the write |
| rd_mask | input | 6 | Field mask for the read |
| rd_data | output | 32 | Masked read data |
| set_ovf | input | 8 | Sideband set of overflow bits [23:16] |
| set_efail | input | 1 | Sideband set of extract-fail bit 14 |
| pos_load | input | 1 | Load position field |
| pos_value | input | 6 | New position value |
| acc_valid | input | 1 | Accumulator command valid |
| acc_ready | output | 1 | Accumulator command ready (always high) |
| acc_op | input | 1 | 0 = shift, 1 = push |
| acc_sel | input | 2 | Target accumulator |
| acc_operand | input | 32 | Push data, or shift amount in [5:0] |
| acc_rd_sel | input | 2 | Accumulator read select |
| acc_rd_hi | output | 32 | HI half of the selected accumulator |
| acc_rd_lo | output | 32 | LO half of the selected accumulator |

## Verification
Assertions check four properties on every cycle: the two reserved bits stay zero, sideband sets always land, a position load is taken, and a push moves LO into HI while leaving every untargeted accumulator unchanged. The bench scenarios cover behaviour that depends on data values: the field map of masked writes and reads, the exact results of right and left shifts (including the -32 and +31 limits), the position wrap from 32 to 0, and how a write, a push and a position load resolve their priority when they coincide.

// File: rtl/dspc_pkg.sv
package dspc_pkg;
  localparam int CTL_W   = 32;
  localparam int MASK_W  = 6;
  localparam int POS_W   = 6;
  localparam int OVF_LSB = 16;
  localparam int OVF_W   = 8;
  localparam int EFAIL_BIT = 14;
  localparam int RSVD_A  = 6;
  localparam int RSVD_B  = 15;

  typedef enum logic {
    ACC_SHIFT = 1'b0,
    ACC_PUSH  = 1'b1
  } acc_op_e;

  // Bits of the control word covered by one mask bit.
  function automatic logic [CTL_W-1:0] field_bits(input int idx);
    logic [CTL_W-1:0] b;
    b = '0;
    case (idx)
      0: b[5:0]   = '1;
      1: b[12:7]  = '1;
      2: b[13]    = 1'b1;
      3: b[23:16] = '1;
      4: b[31:24] = '1;
      5: b[14]    = 1'b1;
      default: b = '0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dspc_field_mask.sv
module dspc_field_mask
  import dspc_pkg::*;
(
  input  logic [MASK_W-1:0] sel,
  output logic [CTL_W-1:0]  bits
);
  logic [CTL_W-1:0] part [MASK_W];

  for (genvar i = 0; i < MASK_W; i++) begin : g_field
    assign part[i] = sel[i] ? field_bits(i) : '0;
  end

  always_comb begin
    bits = '0;
    for (int i = 0; i < MASK_W; i++) bits = bits | part[i];
  end
endmodule

// File: rtl/dspc_ctl_reg.sv
module dspc_ctl_reg
  import dspc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic [CTL_W-1:0]  wr_bits,
  input  logic              pos_load,
  input  logic [POS_W-1:0]  pos_val,
  input  logic              push_fire,
  input  logic [OVF_W-1:0]  set_ovf,
  input  logic              set_efail,
  output logic [CTL_W-1:0]  ctl
);
  localparam logic [POS_W-1:0] POS_STEP = POS_W'(32);

  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_fire) ctl_d = (ctl_q & ~wr_bits) | (wr_data & wr_bits);
    if (pos_load)
      ctl_d[POS_W-1:0] = pos_val;
    else if (push_fire && ctl_q[POS_W-1:0] <= POS_STEP)
      ctl_d[POS_W-1:0] = ctl_q[POS_W-1:0] + POS_STEP;
    else if (push_fire)
      ctl_d[POS_W-1:0] = ctl_q[POS_W-1:0];
    ctl_d[OVF_LSB +: OVF_W] = ctl_d[OVF_LSB +: OVF_W] | set_ovf;
    ctl_d[EFAIL_BIT]        = ctl_d[EFAIL_BIT] | set_efail;
    ctl_d[RSVD_A] = 1'b0;
    ctl_d[RSVD_B] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  // R4: reserved bits never hold a one
  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[RSVD_A] == 1'b0) && (ctl_q[RSVD_B] == 1'b0));

  // R5: sideband extract-fail set always lands
  assert_efail_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_efail |=> ctl_q[EFAIL_BIT]);

  // R5: sideband overflow bits always land
  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ovf) |=> ((ctl_q[OVF_LSB +: OVF_W] & $past(set_ovf)) == $past(set_ovf)));

  // R6: position load wins
  assert_pos_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pos_load |=> (ctl_q[POS_W-1:0] == $past(pos_val)));

  // R8: a push above 32 leaves the position alone
  assert_push_pos_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !pos_load && ctl_q[POS_W-1:0] > POS_STEP) |=> $stable(ctl_q[POS_W-1:0]));
endmodule

// File: rtl/dspc_acc_shift.sv
module dspc_acc_shift #(
  parameter int ACC_W = 64,
  parameter int AMT_W = 6
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [AMT_W-1:0] amt,
  output logic [ACC_W-1:0] acc_out
);
  logic [AMT_W-1:0] mag;

  always_comb begin
    mag = AMT_W'(-amt);
    if (amt == '0)         acc_out = acc_in;
    else if (!amt[AMT_W-1]) acc_out = acc_in >> amt;
    else                   acc_out = acc_in << mag;
  end
endmodule

// File: rtl/dspc_acc_file.sv
module dspc_acc_file #(
  parameter int DATA_W = 32,
  parameter int ACC_N  = 4,
  parameter int AMT_W  = 6,
  localparam int SEL_W = $clog2(ACC_N),
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              op_push,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] operand,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_hi,
  output logic [DATA_W-1:0] rd_lo
);
  logic [DATA_W-1:0] hi_q [ACC_N];
  logic [DATA_W-1:0] lo_q [ACC_N];
  logic [ACC_W-1:0]  cur, shifted;
  logic [DATA_W-1:0] new_hi, new_lo;

  assign cur = {hi_q[sel], lo_q[sel]};

  dspc_acc_shift #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_shift (
    .acc_in (cur),
    .amt    (operand[AMT_W-1:0]),
    .acc_out(shifted)
  );

  always_comb begin
    if (op_push) begin
      new_hi = lo_q[sel];
      new_lo = operand;
    end else begin
      new_hi = shifted[ACC_W-1:DATA_W];
      new_lo = shifted[DATA_W-1:0];
    end
  end

  for (genvar i = 0; i < ACC_N; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end else if (fire && sel == SEL_W'(i)) begin
        hi_q[i] <= new_hi;
        lo_q[i] <= new_lo;
      end
    end

    // R11: untargeted entries hold
    assert_entry_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && sel == SEL_W'(i)) |=> ($stable(hi_q[i]) && $stable(lo_q[i])));
  end

  assign rd_hi = hi_q[rd_sel];
  assign rd_lo = lo_q[rd_sel];

  // R7: push moves the old LO into HI and loads LO
  assert_push_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_push) |=> (hi_q[$past(sel)] == $past(lo_q[sel]) &&
                           lo_q[$past(sel)] == $past(operand)));
endmodule

// File: rtl/dspc_unit.sv
module dspc_unit
  import dspc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [31:0] wr_data,
  input  logic [5:0]  wr_mask,
  input  logic [5:0]  rd_mask,
  output logic [31:0] rd_data,
  input  logic [7:0]  set_ovf,
  input  logic        set_efail,
  input  logic        pos_load,
  input  logic [5:0]  pos_value,
  input  logic        acc_valid,
  output logic        acc_ready,
  input  logic        acc_op,
  input  logic [1:0]  acc_sel,
  input  logic [31:0] acc_operand,
  input  logic [1:0]  acc_rd_sel,
  output logic [31:0] acc_rd_hi,
  output logic [31:0] acc_rd_lo
);
  localparam int ACC_N = 4;

  logic [CTL_W-1:0] wr_bits, rd_bits, ctl;
  logic wr_fire, acc_fire, push_fire;

  assign wr_ready  = 1'b1;
  assign acc_ready = 1'b1;
  assign wr_fire   = wr_valid && wr_ready;
  assign acc_fire  = acc_valid && acc_ready;
  assign push_fire = acc_fire && (acc_op_e'(acc_op) == ACC_PUSH);

  dspc_field_mask u_wmask (.sel(wr_mask), .bits(wr_bits));
  dspc_field_mask u_rmask (.sel(rd_mask), .bits(rd_bits));

  dspc_ctl_reg u_ctl (
    .clk, .rst_n,
    .wr_fire  (wr_fire),
    .wr_data  (wr_data),
    .wr_bits  (wr_bits),
    .pos_load (pos_load),
    .pos_val  (pos_value),
    .push_fire(push_fire),
    .set_ovf  (set_ovf),
    .set_efail(set_efail),
    .ctl      (ctl)
  );

  assign rd_data = ctl & rd_bits;

  dspc_acc_file #(.DATA_W(32), .ACC_N(ACC_N), .AMT_W(6)) u_acc (
    .clk, .rst_n,
    .fire   (acc_fire),
    .op_push(acc_op),
    .sel    (acc_sel),
    .operand(acc_operand),
    .rd_sel (acc_rd_sel),
    .rd_hi  (acc_rd_hi),
    .rd_lo  (acc_rd_lo)
  );
endmodule

// File: tb/dspc_unit_test.sv
`timescale 1ns/1ps
module dspc_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, wr_ready;
  logic [31:0] wr_data = '0;
  logic [5:0] wr_mask = '0, rd_mask = '0;
  logic [31:0] rd_data;
  logic [7:0] set_ovf = '0;
  logic set_efail = 0, pos_load = 0;
  logic [5:0] pos_value = '0;
  logic acc_valid = 0, acc_ready, acc_op = 0;
  logic [1:0] acc_sel = '0, acc_rd_sel = '0;
  logic [31:0] acc_operand = '0, acc_rd_hi, acc_rd_lo;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dspc_unit uut (.*);

  typedef struct packed {
    logic [5:0]  wm;
    logic [31:0] wd;
    logic [5:0]  rm;
    logic [31:0] ex;
  } vec_t;

  // R2/R3/R4 walk, cumulative from the reset state
  localparam vec_t VECS [9] = '{
    '{6'h3F, 32'hFFFFFFFF, 6'h3F, 32'hFFFF7FBF},
    '{6'h01, 32'h00000000, 6'h3F, 32'hFFFF7F80},
    '{6'h18, 32'h12345678, 6'h18, 32'h12340000},
    '{6'h06, 32'h00000000, 6'h3F, 32'h12344000},
    '{6'h20, 32'h00000000, 6'h3F, 32'h12340000},
    '{6'h02, 32'h00000A80, 6'h02, 32'h00000A80},
    '{6'h00, 32'hFFFFFFFF, 6'h3F, 32'h12340A80},
    '{6'h01, 32'h0000007F, 6'h3F, 32'h12340ABF},
    '{6'h04, 32'h00002000, 6'h04, 32'h00002000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] m, input string tag, input logic [31:0] exp);
    rd_mask = m;
    #1;
    chk(tag, {32'h0, rd_data}, {32'h0, exp});
  endtask

  task automatic acc_chk(input logic [1:0] s, input string tag, input logic [63:0] exp);
    acc_rd_sel = s;
    #1;
    chk(tag, {acc_rd_hi, acc_rd_lo}, exp);
  endtask

  task automatic cwrite(input logic [5:0] m, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic acc_cmd(input logic op, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_op = op; acc_sel = s; acc_operand = d;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic pload(input logic [5:0] v);
    @(negedge clk);
    pos_load = 1; pos_value = v;
    @(negedge clk);
    pos_load = 0;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h3F, "R1 ctl", 32'h0);
    for (int i = 0; i < 4; i++) acc_chk(2'(i), "R1 acc", 64'h0);
    // R12 ready always high
    chk("R12 ready", {62'h0, wr_ready, acc_ready}, 64'h3);

    for (int i = 0; i < 9; i++) begin
      cwrite(VECS[i].wm, VECS[i].wd);
      rd(VECS[i].rm, $sformatf("R2/R3/R4 vec%0d", i), VECS[i].ex);
    end

    // R5 sideband beats write clearing the same bits
    @(negedge clk);
    wr_valid = 1; wr_mask = 6'h28; wr_data = 32'h0;
    set_ovf = 8'h81; set_efail = 1;
    @(negedge clk);
    wr_valid = 0; set_ovf = 0; set_efail = 0;
    rd(6'h3F, "R5 set wins", 32'h12816ABF);

    // R6 position load
    pload(6'd10);
    rd(6'h01, "R6 pos load", 32'h0000000A);

    // R7/R8 push
    acc_cmd(1'b1, 2'd2, 32'hAAAA0001);
    acc_chk(2'd2, "R7 push1", 64'h00000000_AAAA0001);
    rd(6'h01, "R8 pos +32", 32'h0000002A);
    acc_cmd(1'b1, 2'd2, 32'h55550002);
    acc_chk(2'd2, "R7 push2", 64'hAAAA0001_55550002);
    rd(6'h01, "R8 pos hold above 32", 32'h0000002A);

    // R9/R10 shifts
    acc_cmd(1'b0, 2'd2, 32'h00000004);
    acc_chk(2'd2, "R9 right 4", 64'h0AAAA000_15555000);
    acc_cmd(1'b0, 2'd2, 32'h00000038);
    acc_chk(2'd2, "R10 left 8", 64'hAAA00015_55500000);
    acc_cmd(1'b0, 2'd2, 32'hFFFFFFC0);
    acc_chk(2'd2, "R10 zero", 64'hAAA00015_55500000);
    acc_cmd(1'b0, 2'd2, 32'h00000020);
    acc_chk(2'd2, "R10 left 32", 64'h55500000_00000000);
    acc_cmd(1'b0, 2'd2, 32'h0000001F);
    acc_chk(2'd2, "R9 right 31", 64'h00000000_AAA00000);

    // R11 other entries untouched
    acc_chk(2'd0, "R11 acc0", 64'h0);
    acc_chk(2'd3, "R11 acc3", 64'h0);

    // R8 wrap 32 -> 0
    pload(6'd32);
    acc_cmd(1'b1, 2'd1, 32'h00000011);
    rd(6'h01, "R8 wrap", 32'h0);
    acc_chk(2'd1, "R7 acc1", 64'h00000000_00000011);

    // R8 push beats masked write of the position
    pload(6'd3);
    @(negedge clk);
    wr_valid = 1; wr_mask = 6'h01; wr_data = 32'h3F;
    acc_valid = 1; acc_op = 1; acc_sel = 2'd3; acc_operand = 32'h7;
    @(negedge clk);
    wr_valid = 0; acc_valid = 0;
    rd(6'h01, "R8 push over write", 32'h00000023);

    // R6 priority over push and write together
    @(negedge clk);
    wr_valid = 1; wr_mask = 6'h01; wr_data = 32'h3F;
    acc_valid = 1; acc_op = 1; acc_sel = 2'd3; acc_operand = 32'h9;
    pos_load = 1; pos_value = 6'd5;
    @(negedge clk);
    wr_valid = 0; acc_valid = 0; pos_load = 0;
    rd(6'h01, "R6 priority", 32'h00000005);
    acc_chk(2'd3, "R7 acc3", 64'h00000007_00000009);

    // R1 reset again clears everything
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rd(6'h3F, "R1 re-reset ctl", 32'h0);
    acc_chk(2'd2, "R1 re-reset acc", 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule